// File: doc/BRIEF.md
# Configuration-space unlock gate for a legacy I/O controller

This block holds the configuration space of a legacy I/O controller that the host reaches through a pair of byte ports. One is an index port at the strapped base address and the other is a data port one address above it. The configuration space starts hidden. The block watches byte writes to the index port for a four-byte unlock key. The key ends in a byte that depends on which of the two base addresses the board strap selects.

Once the block is unlocked, a write to the index port selects a configuration register, and the data port reads or writes that register. The register file holds:
- a read-only chip identity (two bytes) and a revision byte;
- a logical-device selector;
- a global flash-control byte;
- a 16-bit serial-flash port base, which is visible only while the flash logical device is selected.

Writing the exit code to the exit register hides the space again. Decoding the host bus into write and read strobes is done outside this block.

Top module: `sio_cfg_gate`

## Requirements
- R1: After reset the block is locked (`cfg_open`=0) and `io_rdata` is 0xFF. The index register, the logical-device selector and the flash-control byte are 0x00. The flash port base is the parameter default (0x0820 in the bench).
- R2: With `base_strap`=0 (base 0x2E), the index-port write sequence 0x87, 0x01, 0x55, 0x55 unlocks the block. `cfg_open` is 1 after the clock edge that takes the last byte.
- R3: With `base_strap`=1 (base 0x4E), the key ends in 0xAA instead of 0x55. A key ending in 0x55 leaves this mode locked, and a key ending in 0xAA leaves `base_strap`=0 locked.
- R4: While locked, an index-port byte that does not match the next key byte restarts detection. If that byte is 0x87, it counts as the first key byte.
- R5: While locked, data-port reads return 0xFF and index-port reads return 0xFF. Data-port writes change no register and do not advance the key.
- R6: Indices 0x20, 0x21 and 0x22 read the chip identity high byte, the low byte and the revision from parameters. Writes to them have no effect.
- R7: Index 0x24 is the flash-control byte. Bits 5:0 are writable and bits 7:6 always read 0. The fields are: bit 0 suspend, bits 3:1 segment enables, bit 4 write enable, bit 5 pin select.
- R8: Index 0x07 selects the logical device. When the logical device equals the flash device number (7), indices 0x64 and 0x65 read and write the high and low bytes of the flash port base. Under any other logical device these indices read 0x00 and ignore writes.
- R9: While unlocked, writing 0x02 to index 0x02 locks the block after that clock edge. Any other value written there has no effect.
- R10: A read strobe updates `io_rdata` at the next clock edge, and `io_rdata` holds its value between read strobes. While unlocked, an index-port read returns the current index, and unmapped indices read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_strap | input | 1 | Base address strap: 0 selects 0x2E, 1 selects 0x4E |
| io_wr | input | 1 | Single-cycle byte write strobe |
| io_rd | input | 1 | Single-cycle byte read strobe |
| io_sel_data | input | 1 | 0 addresses the index port, 1 addresses the data port |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data, registered on the read strobe |
| cfg_open | output | 1 | High while the configuration space is unlocked |

## Verification
The bench attacks the key detector with interrupted and repeated sequences. One case is a doubled 0x87, which a detector that drops a stray 0x87 back to idle would reject. Another is a foreign byte in the third position, which a detector that only holds or advances would let through to unlock. It also sends each key tail under the opposite strap, and it sends the full key on the data port while locked, which catches a detector that does not qualify on the port select. On the register side it checks the read-zero bits of the flash-control byte, flash-base writes made under the wrong logical device, and a non-exit value written to the exit register. A design that skipped the logical-device check or decoded the exit register too loosely would show a wrong read value or drop `cfg_open` where it should not.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam int CFG_W   = 8;
    localparam int KEY_LEN = 4;
    localparam int KEY_PW  = $clog2(KEY_LEN);

    typedef logic [CFG_W-1:0] cfg_byte_t;

    // Key bytes that do not depend on the strap
    localparam cfg_byte_t KEY_LEAD  = 8'h87;
    localparam cfg_byte_t KEY_SEC   = 8'h01;
    localparam cfg_byte_t KEY_THIRD = 8'h55;
    localparam cfg_byte_t TAIL_LOW  = 8'h55;   // base 0x2E
    localparam cfg_byte_t TAIL_HIGH = 8'hAA;   // base 0x4E

    // Configuration indices
    localparam cfg_byte_t IX_EXIT     = 8'h02;
    localparam cfg_byte_t IX_DEVSEL   = 8'h07;
    localparam cfg_byte_t IX_ID_HI    = 8'h20;
    localparam cfg_byte_t IX_ID_LO    = 8'h21;
    localparam cfg_byte_t IX_REV      = 8'h22;
    localparam cfg_byte_t IX_FCTL     = 8'h24;
    localparam cfg_byte_t IX_FBASE_HI = 8'h64;
    localparam cfg_byte_t IX_FBASE_LO = 8'h65;

    localparam cfg_byte_t EXIT_CODE   = 8'h02;
    localparam cfg_byte_t FCTL_MASK   = 8'h3F;
    localparam cfg_byte_t HIDDEN_READ = 8'hFF;

    typedef enum logic [KEY_PW-1:0] {
        KS_IDLE = 2'd0,
        KS_ONE  = 2'd1,
        KS_TWO  = 2'd2,
        KS_THREE = 2'd3
    } key_st_t;

    typedef struct packed {
        logic      wr;
        logic      rd;
        logic      at_data;
        cfg_byte_t wdata;
    } io_req_t;

    function automatic cfg_byte_t key_byte(input key_st_t pos, input logic strap);
        case (pos)
            KS_IDLE:  return KEY_LEAD;
            KS_ONE:   return KEY_SEC;
            KS_TWO:   return KEY_THIRD;
            default:  return strap ? TAIL_HIGH : TAIL_LOW;
        endcase
    endfunction

endpackage

// File: rtl/sio_key_detect.sv
module sio_key_detect
    import sio_cfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      armed,
    input  logic      strobe,
    input  cfg_byte_t wdata,
    input  logic      strap,
    output logic      hit
);

    key_st_t st_q;
    logic    match;

    assign match = (wdata == key_byte(st_q, strap));
    assign hit   = armed && strobe && match && (st_q == KS_THREE);

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            st_q <= KS_IDLE;
        end else if (strobe) begin
            if (match)
                st_q <= (st_q == KS_THREE) ? KS_IDLE : key_st_t'(st_q + 2'd1);
            else
                st_q <= (wdata == KEY_LEAD) ? KS_ONE : KS_IDLE;
        end
    end

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
#(
    parameter cfg_byte_t   ID_HI     = 8'h87,
    parameter cfg_byte_t   ID_LO     = 8'h16,
    parameter cfg_byte_t   REV       = 8'h01,
    parameter cfg_byte_t   FLASH_DEV = 8'h07,
    parameter logic [15:0] FBASE_DEF = 16'h0820
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      open,
    input  io_req_t   req,
    output cfg_byte_t rdata,
    output logic      exit_req,
    output cfg_byte_t index_q,
    output cfg_byte_t ldn_q
);

    cfg_byte_t   fctl_q;
    logic [15:0] fbase_q;
    cfg_byte_t   reg_val;
    logic        flash_dev_sel;
    logic        data_wr;

    assign flash_dev_sel = (ldn_q == FLASH_DEV);
    assign data_wr       = open && req.wr && req.at_data;
    assign exit_req      = data_wr && (index_q == IX_EXIT) && (req.wdata == EXIT_CODE);

    always_comb begin
        case (index_q)
            IX_DEVSEL:   reg_val = ldn_q;
            IX_ID_HI:    reg_val = ID_HI;
            IX_ID_LO:    reg_val = ID_LO;
            IX_REV:      reg_val = REV;
            IX_FCTL:     reg_val = fctl_q;
            IX_FBASE_HI: reg_val = flash_dev_sel ? fbase_q[15:8] : '0;
            IX_FBASE_LO: reg_val = flash_dev_sel ? fbase_q[7:0]  : '0;
            default:     reg_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= '0;
            ldn_q   <= '0;
            fctl_q  <= '0;
            fbase_q <= FBASE_DEF;
            rdata   <= HIDDEN_READ;
        end else begin
            if (req.rd) begin
                if (!open)
                    rdata <= HIDDEN_READ;
                else
                    rdata <= req.at_data ? reg_val : index_q;
            end
            if (open && req.wr && !req.at_data)
                index_q <= req.wdata;
            if (data_wr) begin
                case (index_q)
                    IX_DEVSEL: ldn_q  <= req.wdata;
                    IX_FCTL:   fctl_q <= req.wdata & FCTL_MASK;
                    IX_FBASE_HI: if (flash_dev_sel) fbase_q[15:8] <= req.wdata;
                    IX_FBASE_LO: if (flash_dev_sel) fbase_q[7:0]  <= req.wdata;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sio_cfg_gate.sv
module sio_cfg_gate
    import sio_cfg_pkg::*;
#(
    parameter cfg_byte_t   ID_HI     = 8'h87,
    parameter cfg_byte_t   ID_LO     = 8'h16,
    parameter cfg_byte_t   REV       = 8'h01,
    parameter cfg_byte_t   FLASH_DEV = 8'h07,
    parameter logic [15:0] FBASE_DEF = 16'h0820
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       base_strap,
    input  logic       io_wr,
    input  logic       io_rd,
    input  logic       io_sel_data,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    output logic       cfg_open
);

    io_req_t   req;
    logic      key_hit;
    logic      exit_req;
    cfg_byte_t index_q;
    cfg_byte_t ldn_q;
    logic      open_q;

    assign req = '{wr: io_wr, rd: io_rd, at_data: io_sel_data, wdata: io_wdata};

    sio_key_detect key_i (
        .clk    (clk),
        .rst    (rst),
        .armed  (!open_q),
        .strobe (io_wr && !io_sel_data),
        .wdata  (io_wdata),
        .strap  (base_strap),
        .hit    (key_hit)
    );

    sio_cfg_regs #(
        .ID_HI     (ID_HI),
        .ID_LO     (ID_LO),
        .REV       (REV),
        .FLASH_DEV (FLASH_DEV),
        .FBASE_DEF (FBASE_DEF)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .open     (open_q),
        .req      (req),
        .rdata    (io_rdata),
        .exit_req (exit_req),
        .index_q  (index_q),
        .ldn_q    (ldn_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            open_q <= 1'b0;
        else if (key_hit)
            open_q <= 1'b1;
        else if (exit_req)
            open_q <= 1'b0;
    end

    assign cfg_open = open_q;

endmodule

// File: rtl/sio_cfg_checker.sv
module sio_cfg_checker
    import sio_cfg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       base_strap,
    input logic       io_wr,
    input logic       io_rd,
    input logic       io_sel_data,
    input logic [7:0] io_wdata,
    input logic [7:0] io_rdata,
    input logic       cfg_open,
    input logic [7:0] cur_index,
    input logic [7:0] cur_ldn
);

    // R2 / R3: unlocking only follows an index write of the strap's tail byte
    a_r2_unlock_by_tail: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open) |-> $past(io_wr && !io_sel_data &&
                                  io_wdata == (base_strap ? TAIL_HIGH : TAIL_LOW)));

    // R5: hidden data reads
    a_r5_locked_reads_ff: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && io_rd && io_sel_data) |=> (io_rdata == HIDDEN_READ));

    // R8: device selector changes only via an unlocked data write
    a_r8_ldn_stable: assert property (@(posedge clk) disable iff (rst)
        !(cfg_open && io_wr && io_sel_data) |=> $stable(cur_ldn));

    // R9: exit code at the exit index locks
    a_r9_exit_locks: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && io_wr && io_sel_data && cur_index == IX_EXIT &&
         io_wdata == EXIT_CODE) |=> !cfg_open);

    // R10: read data holds without a read strobe
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !io_rd |=> $stable(io_rdata));

endmodule

bind sio_cfg_gate sio_cfg_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .base_strap  (base_strap),
    .io_wr       (io_wr),
    .io_rd       (io_rd),
    .io_sel_data (io_sel_data),
    .io_wdata    (io_wdata),
    .io_rdata    (io_rdata),
    .cfg_open    (cfg_open),
    .cur_index   (index_q),
    .cur_ldn     (ldn_q)
);

// File: tb/sio_cfg_gate_tb.sv
module sio_cfg_gate_tb_top;

    localparam logic [7:0]  P_ID_HI = 8'h87;
    localparam logic [7:0]  P_ID_LO = 8'h16;
    localparam logic [7:0]  P_REV   = 8'h01;
    localparam logic [15:0] P_FBASE = 16'h0820;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       base_strap = 1'b0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic       io_sel_data = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       cfg_open;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;   // 50 MHz

    sio_cfg_gate #(
        .ID_HI(P_ID_HI), .ID_LO(P_ID_LO), .REV(P_REV),
        .FLASH_DEV(8'h07), .FBASE_DEF(P_FBASE)
    ) dut_i (
        .clk(clk), .rst(rst), .base_strap(base_strap),
        .io_wr(io_wr), .io_rd(io_rd), .io_sel_data(io_sel_data),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open)
    );

    // ---------------- behavioural reference model ----------------
    int          m_key;
    bit          m_open;
    logic [7:0]  m_idx, m_ldn, m_fctl, m_rd;
    logic [15:0] m_fbase;

    function automatic logic [7:0] key_at(int pos);
        case (pos)
            0: return 8'h87;
            1: return 8'h01;
            2: return 8'h55;
            default: return base_strap ? 8'hAA : 8'h55;
        endcase
    endfunction

    function automatic logic [7:0] m_lookup();
        if (m_idx == 8'h07) return m_ldn;
        if (m_idx == 8'h20) return P_ID_HI;
        if (m_idx == 8'h21) return P_ID_LO;
        if (m_idx == 8'h22) return P_REV;
        if (m_idx == 8'h24) return m_fctl;
        if (m_idx == 8'h64 && m_ldn == 8'h07) return m_fbase[15:8];
        if (m_idx == 8'h65 && m_ldn == 8'h07) return m_fbase[7:0];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_key = 0; m_open = 0; m_idx = 0; m_ldn = 0; m_fctl = 0;
            m_fbase = P_FBASE; m_rd = 8'hFF;
        end else begin
            if (io_rd)
                m_rd = !m_open ? 8'hFF : (io_sel_data ? m_lookup() : m_idx);
            if (io_wr) begin
                if (!m_open) begin
                    if (!io_sel_data) begin
                        if (io_wdata == key_at(m_key)) begin
                            m_key = m_key + 1;
                            if (m_key == 4) begin m_open = 1; m_key = 0; end
                        end else begin
                            m_key = (io_wdata == 8'h87) ? 1 : 0;
                        end
                    end
                end else if (!io_sel_data) begin
                    m_idx = io_wdata;
                end else begin
                    if (m_idx == 8'h02 && io_wdata == 8'h02) begin m_open = 0; m_key = 0; end
                    if (m_idx == 8'h07) m_ldn = io_wdata;
                    if (m_idx == 8'h24) m_fctl = io_wdata & 8'h3F;
                    if (m_idx == 8'h64 && m_ldn == 8'h07) m_fbase[15:8] = io_wdata;
                    if (m_idx == 8'h65 && m_ldn == 8'h07) m_fbase[7:0] = io_wdata;
                end
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_cmp++;
            if (io_rdata !== m_rd || cfg_open !== m_open) begin
                n_bad++;
                $display("FAIL %s model compare: rdata=%h open=%b expected rdata=%h open=%b",
                         cur_req, io_rdata, cfg_open, m_rd, m_open);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1; io_sel_data = sel; io_wdata = d;
        @(negedge clk);
        io_wr = 0;
    endtask

    task automatic key4(input logic [7:0] a, b, c, d);
        wr(0, a); wr(0, b); wr(0, c); wr(0, d);
    endtask

    task automatic rd_chk(input logic sel, input logic [7:0] exp, input string tag);
        @(negedge clk);
        io_rd = 1; io_sel_data = sel;
        @(negedge clk);
        io_rd = 0;
        n_cmp++;
        if (io_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s read: got %h expected %h", tag, io_rdata, exp);
        end
    endtask

    task automatic reg_chk(input logic [7:0] ix, input logic [7:0] exp, input string tag);
        wr(0, ix);
        rd_chk(1, exp, tag);
    endtask

    task automatic open_chk(input logic exp, input string tag);
        @(negedge clk);
        n_cmp++;
        if (cfg_open !== exp) begin
            n_bad++;
            $display("FAIL %s open flag: got %b expected %b", tag, cfg_open, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    // ---------------- test sequence ----------------
    initial begin
        base_strap = 0;
        do_reset();
        cur_req = "R1";
        open_chk(0, "R1");
        rd_chk(1, 8'hFF, "R1");
        rd_chk(0, 8'hFF, "R5");

        cur_req = "R3";
        key4(8'h87, 8'h01, 8'h55, 8'hAA);
        open_chk(0, "R3");

        cur_req = "R5";
        wr(1, 8'h87); wr(1, 8'h01); wr(1, 8'h55); wr(1, 8'h55);
        open_chk(0, "R5");
        rd_chk(1, 8'hFF, "R5");

        cur_req = "R4";
        wr(0, 8'h87);
        key4(8'h87, 8'h01, 8'h55, 8'h55);
        open_chk(1, "R4");
        reg_chk(8'h02, 8'h00, "R10");
        wr(1, 8'h02);
        open_chk(0, "R9");

        cur_req = "R2";
        key4(8'h87, 8'h01, 8'h55, 8'h55);
        open_chk(1, "R2");

        cur_req = "R6";
        reg_chk(8'h20, P_ID_HI, "R6");
        reg_chk(8'h21, P_ID_LO, "R6");
        reg_chk(8'h22, P_REV, "R6");
        wr(0, 8'h20); wr(1, 8'h00);
        rd_chk(1, P_ID_HI, "R6");

        cur_req = "R9";
        wr(0, 8'h02); wr(1, 8'h05);
        open_chk(1, "R9");

        cur_req = "R7";
        wr(0, 8'h24); wr(1, 8'hFF);
        rd_chk(1, 8'h3F, "R7");
        rd_chk(0, 8'h24, "R10");
        wr(1, 8'h0A);
        rd_chk(1, 8'h0A, "R7");

        cur_req = "R8";
        reg_chk(8'h07, 8'h00, "R1");
        reg_chk(8'h64, 8'h00, "R8");
        wr(1, 8'h99);
        wr(0, 8'h07); wr(1, 8'h07);
        rd_chk(1, 8'h07, "R8");
        reg_chk(8'h64, P_FBASE[15:8], "R8");
        reg_chk(8'h65, P_FBASE[7:0], "R1");
        wr(0, 8'h64); wr(1, 8'h0A);
        wr(0, 8'h65); wr(1, 8'h30);
        reg_chk(8'h64, 8'h0A, "R8");
        reg_chk(8'h65, 8'h30, "R8");
        reg_chk(8'h30, 8'h00, "R10");

        cur_req = "R9";
        wr(0, 8'h02); wr(1, 8'h02);
        open_chk(0, "R9");
        rd_chk(1, 8'hFF, "R5");
        wr(1, 8'h07);
        rd_chk(1, 8'hFF, "R5");

        cur_req = "R3";
        base_strap = 1;
        do_reset();
        key4(8'h87, 8'h01, 8'h55, 8'h55);
        open_chk(0, "R3");
        key4(8'h87, 8'h01, 8'h55, 8'hAA);
        open_chk(1, "R3");
        reg_chk(8'h07, 8'h00, "R1");
        wr(0, 8'h02); wr(1, 8'h02);
        open_chk(0, "R9");

        cur_req = "R4";
        wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h33); wr(0, 8'h55); wr(0, 8'hAA);
        open_chk(0, "R4");
        key4(8'h87, 8'h01, 8'h55, 8'hAA);
        open_chk(1, "R4");

        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule